// File: doc/BRIEF.md
# Max-log-MAP A-Posteriori and Extrinsic Output Stage

This block is the last stage of a soft-in soft-out component decoder working on an 8-state binary trellis. For one trellis step it receives the eight forward state metrics of the previous step, the eight backward state metrics of the current step and the sixteen branch metrics of that step. It forms the a-posteriori log-likelihood ratio of the information bit. It then removes the a-priori, systematic and parity contributions to produce the extrinsic value, which is passed to the other component decoder.

Each of the two candidate sets has eight path sums, and each set is reduced by a balanced three-level tree of pairwise max-star nodes. A static input selects, for the whole tree, either the max-star with a small correction table or the plain maximum. The first two tree levels and the output stage are registered, so a new trellis step can enter every cycle. A valid flag travels alongside the data. All metrics are signed fixed-point numbers with one LSB equal to 0.25 in natural-log units.

Top module: `llrx_unit`

## Requirements
- R1: Transition t = 2*s + u leaves state s with input bit u, uses branch metric slice t of `gamma_in` and enters state t mod 8. Its path sum is alpha[s] + gamma[t] + beta[t mod 8], with every field read as signed.
- R2: For each bit value the eight path sums, ordered by source state s, are reduced in three levels. Level one pairs (0,1),(2,3),(4,5),(6,7). Level two pairs the results (01,23) and (45,67). Level three combines the two remaining values.
- R3: With `use_corr` = 1 every node returns max(a,b) - c(min(|a-b|,15)), where c is 3 for d = 0, 2 for d = 1..3, 1 for d = 4..8 and 0 for d >= 9. The values are in metric LSBs.
- R4: With `use_corr` = 0 every node returns max(a,b) exactly.
- R5: `llr_out` is the root for bit 1 minus the root for bit 0, saturated to the signed range of W_LLR bits (-128..127 by default).
- R6: `ext_out` is the unsaturated LLR minus (apri_llr + sys_llr + par_llr), computed at full width and then saturated to W_LLR bits. With all three side inputs zero it equals `llr_out`.
- R7: An input accepted with `in_valid` on a rising edge gives `out_valid` high, with its result, after the third rising edge counting the accepting one. Inputs may arrive on back-to-back cycles, and each one yields exactly one single-cycle `out_valid`.
- R8: While no result is delivered (`out_valid` low), `llr_out` and `ext_out` keep their last values whatever the inputs do.
- R9: An active-low asynchronous reset clears `out_valid`, `llr_out`, `ext_out` and all results in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| use_corr | input | 1 | 1 = corrected max-star, 0 = plain max (static) |
| in_valid | input | 1 | Input metrics valid this cycle |
| alpha_in | input | 8*W_SM | Forward metrics of previous step, state s at bits [s*W_SM +: W_SM] |
| beta_in | input | 8*W_SM | Backward metrics of current step, same layout |
| gamma_in | input | 16*W_BM | Branch metrics, transition t at bits [t*W_BM +: W_BM] |
| apri_llr | input | W_LLR | A-priori LLR of the bit |
| sys_llr | input | W_LLR | Systematic channel LLR |
| par_llr | input | W_LLR | Parity channel LLR |
| out_valid | output | 1 | Result valid |
| llr_out | output | W_LLR | Saturated a-posteriori LLR |
| ext_out | output | W_LLR | Saturated extrinsic LLR |

## Verification
The correction table is exercised with tied and nearly tied path sums, where a wrong threshold or a missing correction shifts the root by one to three LSBs. The same vectors are run with the correction switched off to show that the plain maximum is exact. Vectors with one dominant path check the trellis wiring, since a wrong next-state mapping would add the wrong backward metric. Large metrics and large side inputs drive both outputs into positive and negative saturation, where a wrapping design would flip the sign. The extrinsic subtraction must use the unsaturated LLR, and a design that subtracted from the clipped value would report a value too small. Back-to-back inputs, idle cycles with changing inputs, and a reset with results in flight catch a misaligned valid pipeline, outputs that follow the inputs while idle, and stale results that survive reset.

// File: rtl/llrx_pkg.sv
package llrx_pkg;

    localparam int NSTATE = 8;
    localparam int NTRANS = 2 * NSTATE;
    localparam int CORR_IDX_W = 4;

    // Correction term of ln(1 + e^-d) in quarter units, d in quarter units.
    function automatic logic [1:0] corr_value(input logic [CORR_IDX_W-1:0] d);
        logic [1:0] c;
        if (d == 4'd0)
            c = 2'd3;
        else if (d <= 4'd3)
            c = 2'd2;
        else if (d <= 4'd8)
            c = 2'd1;
        else
            c = 2'd0;
        return c;
    endfunction

endpackage

// File: rtl/llrx_maxstar.sv
module llrx_maxstar
    import llrx_pkg::*;
#(
    parameter int W = 14
) (
    input  logic                use_corr,
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);

    logic signed [W:0]         diff;
    logic        [W:0]         mag;
    logic [CORR_IDX_W-1:0]     idx;
    logic signed [W-1:0]       larger;
    logic [1:0]                cv;

    always_comb begin
        diff   = (W+1)'(a) - (W+1)'(b);
        mag    = diff[W] ? (W+1)'(-diff) : diff;
        idx    = (mag > (W+1)'(15)) ? 4'd15 : mag[CORR_IDX_W-1:0];
        larger = diff[W] ? b : a;
        cv     = use_corr ? corr_value(idx) : 2'd0;
        y      = larger - {{(W-2){1'b0}}, cv};
    end

endmodule

// File: rtl/llrx_path_sum.sv
module llrx_path_sum
    import llrx_pkg::*;
#(
    parameter int W_SM = 12,
    parameter int W_BM = 10,
    parameter int W_S  = 14,
    parameter int BIT  = 0
) (
    input  logic [NSTATE*W_SM-1:0] alpha_in,
    input  logic [NSTATE*W_SM-1:0] beta_in,
    input  logic [NTRANS*W_BM-1:0] gamma_in,
    output logic [NSTATE*W_S-1:0]  sums
);

    for (genvar s = 0; s < NSTATE; s++) begin : g_state
        localparam int TR = 2 * s + BIT;
        localparam int NX = TR % NSTATE;
        assign sums[s*W_S +: W_S] = W_S'($signed(alpha_in[s*W_SM +: W_SM]))
                                  + W_S'($signed(gamma_in[TR*W_BM +: W_BM]))
                                  + W_S'($signed(beta_in[NX*W_SM +: W_SM]));
    end

endmodule

// File: rtl/llrx_tree_level.sv
module llrx_tree_level
    import llrx_pkg::*;
#(
    parameter int W = 14,
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             use_corr,
    input  logic [N*W-1:0]   d_in,
    output logic [N/2*W-1:0] q
);

    localparam int NO = N / 2;

    logic [NO*W-1:0] y_all;

    for (genvar k = 0; k < NO; k++) begin : g_node
        logic signed [W-1:0] y;
        llrx_maxstar #(.W(W)) u_node (
            .use_corr (use_corr),
            .a        (d_in[(2*k)*W +: W]),
            .b        (d_in[(2*k+1)*W +: W]),
            .y        (y)
        );
        assign y_all[k*W +: W] = y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= y_all;
    end

endmodule

// File: rtl/llrx_unit.sv
module llrx_unit
    import llrx_pkg::*;
#(
    parameter int W_SM  = 12,
    parameter int W_BM  = 10,
    parameter int W_LLR = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     use_corr,
    input  logic                     in_valid,
    input  logic [NSTATE*W_SM-1:0]   alpha_in,
    input  logic [NSTATE*W_SM-1:0]   beta_in,
    input  logic [NTRANS*W_BM-1:0]   gamma_in,
    input  logic [W_LLR-1:0]         apri_llr,
    input  logic [W_LLR-1:0]         sys_llr,
    input  logic [W_LLR-1:0]         par_llr,
    output logic                     out_valid,
    output logic [W_LLR-1:0]         llr_out,
    output logic [W_LLR-1:0]         ext_out
);

    localparam int SW     = ((W_SM > W_BM) ? W_SM : W_BM) + 2;
    localparam int SIDE_W = W_LLR + 2;
    localparam int EW     = ((SW + 1 > SIDE_W) ? SW + 1 : SIDE_W) + 1;
    localparam logic signed [EW-1:0] LIM_HI = EW'((2 ** (W_LLR - 1)) - 1);
    localparam logic signed [EW-1:0] LIM_LO = -LIM_HI - EW'(1);

    logic [NSTATE*SW-1:0]   leaf  [2];
    logic [NSTATE/2*SW-1:0] lvl1  [2];
    logic [NSTATE/4*SW-1:0] lvl2  [2];
    logic signed [SW-1:0]   root  [2];

    logic                     v1, v2;
    logic signed [SIDE_W-1:0] side_c, side1, side2;
    logic signed [EW-1:0]     llr_full, ext_full;
    logic [W_LLR-1:0]         llr_sat, ext_sat;

    for (genvar u = 0; u < 2; u++) begin : g_bit
        llrx_path_sum #(.W_SM(W_SM), .W_BM(W_BM), .W_S(SW), .BIT(u)) u_sum (
            .alpha_in (alpha_in),
            .beta_in  (beta_in),
            .gamma_in (gamma_in),
            .sums     (leaf[u])
        );
        llrx_tree_level #(.W(SW), .N(NSTATE)) u_l1 (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (in_valid),
            .use_corr (use_corr),
            .d_in     (leaf[u]),
            .q        (lvl1[u])
        );
        llrx_tree_level #(.W(SW), .N(NSTATE/2)) u_l2 (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (v1),
            .use_corr (use_corr),
            .d_in     (lvl1[u]),
            .q        (lvl2[u])
        );
        llrx_maxstar #(.W(SW)) u_root (
            .use_corr (use_corr),
            .a        (lvl2[u][0 +: SW]),
            .b        (lvl2[u][SW +: SW]),
            .y        (root[u])
        );
    end

    // Side information summed at entry and carried with the tree.
    assign side_c = SIDE_W'($signed(apri_llr)) + SIDE_W'($signed(sys_llr))
                  + SIDE_W'($signed(par_llr));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            v2    <= 1'b0;
            side1 <= '0;
            side2 <= '0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            if (in_valid)
                side1 <= side_c;
            if (v1)
                side2 <= side1;
        end
    end

    always_comb begin
        llr_full = EW'(root[1]) - EW'(root[0]);
        ext_full = llr_full - EW'(side2);

        if (llr_full > LIM_HI)
            llr_sat = {1'b0, {(W_LLR-1){1'b1}}};
        else if (llr_full < LIM_LO)
            llr_sat = {1'b1, {(W_LLR-1){1'b0}}};
        else
            llr_sat = llr_full[W_LLR-1:0];

        if (ext_full > LIM_HI)
            ext_sat = {1'b0, {(W_LLR-1){1'b1}}};
        else if (ext_full < LIM_LO)
            ext_sat = {1'b1, {(W_LLR-1){1'b0}}};
        else
            ext_sat = ext_full[W_LLR-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            llr_out   <= '0;
            ext_out   <= '0;
        end else begin
            out_valid <= v2;
            if (v2) begin
                llr_out <= llr_sat;
                ext_out <= ext_sat;
            end
        end
    end

endmodule

// File: rtl/llrx_unit_chk.sv
module llrx_unit_chk #(
    parameter int W_LLR = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [W_LLR-1:0] apri_llr,
    input logic [W_LLR-1:0] sys_llr,
    input logic [W_LLR-1:0] par_llr,
    input logic             out_valid,
    input logic [W_LLR-1:0] llr_out,
    input logic [W_LLR-1:0] ext_out
);

    localparam logic [W_LLR-1:0] MAXV = {1'b0, {(W_LLR-1){1'b1}}};

    logic [2:0] vd;
    logic [2:0] zero_d;
    logic [2:0] nonpos_d;
    logic [1:0] cnt;
    logic       rst_seen = 1'b0;
    logic signed [W_LLR+1:0] side_now;

    assign side_now = (W_LLR+2)'($signed(apri_llr)) + (W_LLR+2)'($signed(sys_llr))
                    + (W_LLR+2)'($signed(par_llr));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd       <= '0;
            zero_d   <= '0;
            nonpos_d <= '0;
            cnt      <= '0;
        end else begin
            vd       <= {vd[1:0], in_valid};
            zero_d   <= {zero_d[1:0], (apri_llr == '0) && (sys_llr == '0) && (par_llr == '0)};
            nonpos_d <= {nonpos_d[1:0], side_now <= 0};
            if (cnt != 2'd3)
                cnt <= cnt + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_seen <= 1'b1;
    end

    // R7: result valid three edges after acceptance
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vd[2]);

    // R8: outputs held while no result is delivered
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= 2'd2 && !out_valid) |-> ($stable(llr_out) && $stable(ext_out)));

    // R9: reset clears outputs
    p_reset_clear_r9: assert property (@(posedge clk)
        (!rst_n && rst_seen) |-> (!out_valid && llr_out == '0 && ext_out == '0));

    // R6: zero side information leaves the LLR unchanged
    p_ext_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 2'd3 && out_valid && zero_d[2]) |-> (ext_out == llr_out));

    // R6: non-positive side sum cannot pull a clipped positive LLR below the limit
    p_ext_pos_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 2'd3 && out_valid && nonpos_d[2] && llr_out == MAXV) |-> (ext_out == MAXV));

endmodule

bind llrx_unit llrx_unit_chk #(.W_LLR(W_LLR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .apri_llr  (apri_llr),
    .sys_llr   (sys_llr),
    .par_llr   (par_llr),
    .out_valid (out_valid),
    .llr_out   (llr_out),
    .ext_out   (ext_out)
);

// File: tb/llrx_unit_test.sv
`timescale 1ns/1ps
module llrx_unit_test;

    localparam int W_SM  = 12;
    localparam int W_BM  = 10;
    localparam int W_LLR = 8;

    // [31] use_corr, [30:24] magnitude, [23:0] seed
    localparam logic [31:0] VEC [10] = '{
        {1'b1, 7'd4,   24'h00A1B2}, {1'b0, 7'd4,   24'h00A1B2},
        {1'b1, 7'd1,   24'h113355}, {1'b1, 7'd12,  24'h2468AC},
        {1'b0, 7'd12,  24'h2468AC}, {1'b1, 7'd30,  24'h0F0F0F},
        {1'b0, 7'd30,  24'h777001}, {1'b1, 7'd90,  24'h5A5A5A},
        {1'b0, 7'd120, 24'h314159}, {1'b1, 7'd0,   24'h000001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic use_corr = 1'b1;
    logic in_valid = 1'b0;
    logic [8*W_SM-1:0]  alpha_in = '0;
    logic [8*W_SM-1:0]  beta_in  = '0;
    logic [16*W_BM-1:0] gamma_in = '0;
    logic [W_LLR-1:0] apri_llr = '0, sys_llr = '0, par_llr = '0;
    logic out_valid;
    logic [W_LLR-1:0] llr_out, ext_out;

    int errors = 0;
    int checks = 0;
    int unsigned rs;
    int av [8];
    int bv [8];
    int gv [16];
    int ap, sy, pa;
    int exp_l, exp_e;

    always #2 clk = ~clk;

    llrx_unit #(.W_SM(W_SM), .W_BM(W_BM), .W_LLR(W_LLR)) uut (
        .clk(clk), .rst_n(rst_n), .use_corr(use_corr), .in_valid(in_valid),
        .alpha_in(alpha_in), .beta_in(beta_in), .gamma_in(gamma_in),
        .apri_llr(apri_llr), .sys_llr(sys_llr), .par_llr(par_llr),
        .out_valid(out_valid), .llr_out(llr_out), .ext_out(ext_out)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int rnd(input int m);
        rs = rs * 32'd1103515245 + 32'd12345;
        return int'((rs >> 16) % (2 * m + 1)) - m;
    endfunction

    function automatic int corr_b(input int d);
        if (d == 0) return 3;
        if (d <= 3) return 2;
        if (d <= 8) return 1;
        return 0;
    endfunction

    function automatic int mstar(input int a, input int b, input bit c);
        int mx = (a >= b) ? a : b;
        int d = (a >= b) ? a - b : b - a;
        return c ? mx - corr_b(d) : mx;
    endfunction

    function automatic int sat(input int x);
        if (x > 127) return 127;
        if (x < -128) return -128;
        return x;
    endfunction

    // Reference from R1..R6
    task automatic model(input bit c);
        int root [2];
        for (int u = 0; u < 2; u++) begin
            int l0 [8];
            int l1 [4];
            int l2 [2];
            for (int s = 0; s < 8; s++)
                l0[s] = av[s] + gv[2*s+u] + bv[(2*s+u) % 8];
            for (int k = 0; k < 4; k++) l1[k] = mstar(l0[2*k], l0[2*k+1], c);
            for (int k = 0; k < 2; k++) l2[k] = mstar(l1[2*k], l1[2*k+1], c);
            root[u] = mstar(l2[0], l2[1], c);
        end
        exp_l = sat(root[1] - root[0]);
        exp_e = sat(root[1] - root[0] - (ap + sy + pa));
    endtask

    task automatic gen(input int unsigned seed, input int mag);
        rs = seed;
        for (int s = 0; s < 8; s++) av[s] = rnd(mag);
        for (int s = 0; s < 8; s++) bv[s] = rnd(mag);
        for (int t = 0; t < 16; t++) gv[t] = rnd(mag / 2);
        ap = sat(rnd(mag)); sy = sat(rnd(mag)); pa = sat(rnd(mag));
    endtask

    task automatic drive_bus();
        for (int s = 0; s < 8; s++) begin
            alpha_in[s*W_SM +: W_SM] = W_SM'(av[s]);
            beta_in[s*W_SM +: W_SM]  = W_SM'(bv[s]);
        end
        for (int t = 0; t < 16; t++) gamma_in[t*W_BM +: W_BM] = W_BM'(gv[t]);
        apri_llr = W_LLR'(ap); sys_llr = W_LLR'(sy); par_llr = W_LLR'(pa);
    endtask

    task automatic run_one(input string req, input bit c);
        use_corr = c;
        model(c);
        @(negedge clk);
        drive_bus();
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R7 no early valid"}, int'(out_valid), 0);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check({req, " R7 valid at third edge"}, int'(out_valid), 1);
        check({req, " R5 llr"}, int'($signed(llr_out)), exp_l);
        check({req, " R6 ext"}, int'($signed(ext_out)), exp_e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int sl [3];
        int se [3];
        logic [8*W_SM-1:0]  sa [3];
        logic [8*W_SM-1:0]  sb [3];
        logic [16*W_BM-1:0] sg [3];
        logic [3*W_LLR-1:0] ss [3];
        int hold_l, hold_e;

        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 reset valid", int'(out_valid), 0);
        check("R9 reset llr", int'(llr_out), 0);
        check("R9 reset ext", int'(ext_out), 0);
        rst_n = 1'b1;

        // R3 R4 R5 R6: table of random vectors in both modes
        for (int i = 0; i < 10; i++) begin
            gen(32'(VEC[i][23:0]), int'(VEC[i][30:24]));
            run_one(VEC[i][31] ? "R3 table" : "R4 table", VEC[i][31]);
        end

        // R3 R2: all path sums equal, correction applied at each level
        for (int s = 0; s < 8; s++) begin av[s] = 0; bv[s] = 0; end
        for (int t = 0; t < 16; t++) gv[t] = (t % 2) ? 5 : 0;
        ap = 0; sy = 0; pa = 0;
        run_one("R3 ties", 1'b1);
        run_one("R4 ties", 1'b0);

        // R1: one dominant transition s=3,u=1 into state 7
        for (int s = 0; s < 8; s++) begin av[s] = -60; bv[s] = -60; end
        for (int t = 0; t < 16; t++) gv[t] = 0;
        av[3] = 0; bv[7] = 0; gv[7] = 40;
        ap = 3; sy = -2; pa = 1;
        run_one("R1 dominant", 1'b1);

        // R5 R6: positive and negative saturation, unsaturated LLR used for ext
        for (int s = 0; s < 8; s++) begin av[s] = 0; bv[s] = 0; end
        for (int t = 0; t < 16; t++) gv[t] = (t % 2) ? 200 : -200;
        ap = 100; sy = 60; pa = 20;
        run_one("R5 R6 pos sat", 1'b1);
        for (int t = 0; t < 16; t++) gv[t] = (t % 2) ? -200 : 200;
        ap = -128; sy = -128; pa = -128;
        run_one("R5 R6 neg sat", 1'b0);
        for (int t = 0; t < 16; t++) gv[t] = (t % 2) ? 10 : -10;
        ap = 127; sy = 127; pa = 100;
        run_one("R6 ext neg sat", 1'b0);

        // R7: back-to-back stream
        for (int k = 0; k < 3; k++) begin
            gen(32'h900 + 32'(k), 20);
            model(1'b1);
            drive_bus();
            sa[k] = alpha_in; sb[k] = beta_in; sg[k] = gamma_in;
            ss[k] = {apri_llr, sys_llr, par_llr};
            sl[k] = exp_l; se[k] = exp_e;
        end
        use_corr = 1'b1;
        for (int cyc = 0; cyc < 6; cyc++) begin
            @(negedge clk);
            if (cyc >= 3) begin
                check("R7 stream valid", int'(out_valid), 1);
                check("R7 stream llr", int'($signed(llr_out)), sl[cyc-3]);
                check("R7 stream ext", int'($signed(ext_out)), se[cyc-3]);
            end else begin
                check("R7 stream not yet", int'(out_valid), 0);
            end
            if (cyc < 3) begin
                alpha_in = sa[cyc]; beta_in = sb[cyc]; gamma_in = sg[cyc];
                {apri_llr, sys_llr, par_llr} = ss[cyc];
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R7 single pulse", int'(out_valid), 0);

        // R8: outputs hold while idle and inputs change
        hold_l = int'(llr_out); hold_e = int'(ext_out);
        for (int k = 0; k < 4; k++) begin
            gen(32'h5000 + 32'(k), 100);
            drive_bus();
            use_corr = ~use_corr;
            @(negedge clk);
            check("R8 hold valid", int'(out_valid), 0);
            check("R8 hold llr", int'(llr_out), hold_l);
            check("R8 hold ext", int'(ext_out), hold_e);
        end

        // R9: reset with a result in flight
        gen(32'h777, 30);
        use_corr = 1'b1;
        drive_bus();
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R9 flushed valid", int'(out_valid), 0);
        end
        check("R9 flushed llr", int'(llr_out), 0);
        check("R9 flushed ext", int'(ext_out), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule